// File: doc/BRIEF.md
# Interleaved memory window target decoder

This block turns a request that lands in a fixed host memory window into a downstream port number. It resolves the port in two interleave levels. The window-relative offset is first made absolute by adding the window base. The absolute address then picks one of up to `NUM_HB` host bridges by modulo over the window's target count, at the window's granularity. The chosen host bridge owns one address decoder. That decoder has a control word and two packed target-list words. When the decoder is committed, it maps the same absolute address to a slot, and the slot yields an 8-bit port number.

Each request is registered once. The lookup result appears in the next cycle as a hit flag, the host-bridge index and the port number. Hits are forwarded downstream with the absolute address. The block completes misses itself: a missed read returns zero data with an error, and a missed write is dropped and reported as successful. Software programs each host bridge's decoder through a small 32-bit write port. The window configuration comes in on static inputs and is checked for validity.

Top module: `ilv_window_decoder`

## Requirements
- R1: After synchronous reset, `lk_vld`, `dn_vld` and `rsp_vld` are 0 and every decoder is uncommitted, so a request misses.
- R2: `lk_vld` is 1 exactly in the cycle after a cycle with `req_vld` high. `lk_hit`, `lk_hb` and `lk_port` are valid in that cycle.
- R3: The absolute address is `cfg_win_base + req_off`. The host-bridge index is `(abs >> (8 + g)) mod cfg_win_tgts`, where `g` is `cfg_gran_enc` when `cfg_gran_set` is 1 and 0 otherwise (0 means 256 bytes).
- R4: Decoder control word layout: bits [3:0] hold the granularity code IG, bits [7:4] hold the ways code IW, and bit 8 is the commit bit. A decoder with commit 0 always misses.
- R5: The slot is `(abs >> (8 + IG)) mod 2^IW`. A slot of 8 or more is a miss.
- R6: Slots 0–3 are read from the low target-list word and slots 4–7 from the high word. Slot s is the 8-bit field at bit `8*(s mod 4)`.
- R7: The configuration is valid only when `cfg_win_size` is nonzero and a multiple of 2^28 bytes and `cfg_win_tgts` is between 1 and `NUM_HB`. Otherwise `cfg_err` is 1 and every request misses.
- R8: A request with `req_off >= cfg_win_size` misses.
- R9: A read that misses gives `rsp_vld`=1, `rsp_err`=1 and `rsp_rdata`=0, with no downstream request.
- R10: A write that misses gives `rsp_vld`=1 and `rsp_err`=0, with no downstream request.
- R11: A hit gives `dn_vld`=1, carrying the port, the absolute address, the direction and the write data, with no `rsp_vld`.
- R12: A register write goes to the decoder of host bridge `reg_hb`. `reg_sel` 0 selects control, 1 the low target list, 2 the high target list, and 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_win_base | input | ADDR_W | Window base address |
| cfg_win_size | input | ADDR_W | Window size in bytes |
| cfg_win_tgts | input | TGT_CNT_W | Number of host bridges in the window |
| cfg_gran_set | input | 1 | Window granularity is configured |
| cfg_gran_enc | input | 4 | Window granularity code |
| cfg_err | output | 1 | Window configuration invalid |
| reg_we | input | 1 | Decoder register write strobe |
| reg_hb | input | HB_IDX_W | Host bridge whose decoder is written |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| req_vld | input | 1 | Request strobe |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_off | input | ADDR_W | Window-relative offset |
| req_wdata | input | 64 | Write data |
| lk_vld | output | 1 | Lookup result valid |
| lk_hit | output | 1 | Lookup found a target |
| lk_hb | output | HB_IDX_W | Selected host-bridge index |
| lk_port | output | 8 | Resolved port number |
| dn_vld | output | 1 | Downstream request valid |
| dn_wr | output | 1 | Downstream request direction |
| dn_port | output | 8 | Downstream port number |
| dn_addr | output | ADDR_W | Absolute address |
| dn_wdata | output | 64 | Downstream write data |
| rsp_vld | output | 1 | Local completion of a missed access |
| rsp_err | output | 1 | Completion carries an error |
| rsp_rdata | output | 64 | Completion read data (zero) |

## Verification
A table of offsets sweeps every slot of two host bridges. The two bridges use different decoder granularities and way counts, so a wrong shift, a wrong modulo or a mis-packed byte each lands on a different port. Directed cases then repeat chosen offsets under changed conditions:
- an uncommitted decoder;
- an out-of-list way count;
- a configured window granularity;
- a three-way window, where modulo differs from masking;
- an invalid window size or target count.

Reads and writes are mixed, so the error and drop paths for misses are told apart from forwarding on hits.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

    localparam int REG_W       = 32;
    localparam int PORT_W      = 8;
    localparam int GRAN_CODE_W = 4;
    localparam int GRAN_SHIFT0 = 8;   // 256-byte base granularity
    localparam int SIZE_ALIGN  = 28;  // window size granule: 256 MiB
    localparam int SLOTS       = 8;
    localparam int SLOTS_PER_W = 4;
    localparam int SLOT_W      = $clog2(SLOTS);

    localparam int CTL_IG_LSB  = 0;
    localparam int CTL_IW_LSB  = 4;
    localparam int CTL_COMMIT  = 8;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_TLO  = 2'd1,
        SEL_THI  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic                   commit;
        logic [GRAN_CODE_W-1:0] ways;
        logic [GRAN_CODE_W-1:0] gran;
    } dec_ctrl_t;

    typedef struct packed {
        logic              hit;
        logic [PORT_W-1:0] port;
    } dec_res_t;

    function automatic dec_ctrl_t ctrl_unpack(input logic [REG_W-1:0] w);
        dec_ctrl_t c;
        c.commit = w[CTL_COMMIT];
        c.ways   = w[CTL_IW_LSB +: GRAN_CODE_W];
        c.gran   = w[CTL_IG_LSB +: GRAN_CODE_W];
        return c;
    endfunction

    function automatic logic [5:0] gran_shift(input logic [GRAN_CODE_W-1:0] code);
        return 6'(GRAN_SHIFT0) + 6'(code);
    endfunction

endpackage

// File: rtl/ilv_win_select.sv
module ilv_win_select
    import ilv_pkg::*;
#(
    parameter int ADDR_W    = 40,
    parameter int NUM_HB    = 4,
    parameter int TGT_CNT_W = $clog2(NUM_HB + 1),
    parameter int HB_IDX_W  = (NUM_HB > 1) ? $clog2(NUM_HB) : 1
) (
    input  logic [ADDR_W-1:0]      win_size_i,
    input  logic [TGT_CNT_W-1:0]   win_tgts_i,
    input  logic                   gran_set_i,
    input  logic [GRAN_CODE_W-1:0] gran_code_i,
    input  logic [ADDR_W-1:0]      abs_addr_i,
    input  logic [ADDR_W-1:0]      off_i,
    output logic                   cfg_ok_o,
    output logic                   in_range_o,
    output logic [HB_IDX_W-1:0]    hb_idx_o
);

    logic [GRAN_CODE_W-1:0] eff_code;
    logic [ADDR_W-1:0]      shifted;
    logic [ADDR_W-1:0]      divisor;
    logic [ADDR_W-1:0]      rem;
    logic                   size_ok;
    logic                   tgts_ok;

    always_comb begin
        size_ok    = (win_size_i != '0) && (win_size_i[SIZE_ALIGN-1:0] == '0);
        tgts_ok    = (win_tgts_i != '0) && (int'(win_tgts_i) <= NUM_HB);
        cfg_ok_o   = size_ok && tgts_ok;
        in_range_o = off_i < win_size_i;

        eff_code   = gran_set_i ? gran_code_i : '0;
        shifted    = abs_addr_i >> gran_shift(eff_code);
        divisor    = tgts_ok ? ADDR_W'(win_tgts_i) : ADDR_W'(1);
        rem        = shifted % divisor;
        hb_idx_o   = HB_IDX_W'(rem);
    end

endmodule

// File: rtl/ilv_hdm_decoder.sv
module ilv_hdm_decoder
    import ilv_pkg::*;
#(
    parameter int ADDR_W = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_sel_i,
    input  logic [REG_W-1:0]  wr_data_i,
    input  logic [ADDR_W-1:0] abs_addr_i,
    output dec_res_t          res_o
);

    dec_ctrl_t          ctrl_q;
    logic [REG_W-1:0]   tlo_q;
    logic [REG_W-1:0]   thi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            tlo_q  <= '0;
            thi_q  <= '0;
        end else if (wr_en_i) begin
            case (reg_sel_e'(wr_sel_i))
                SEL_CTRL: ctrl_q <= ctrl_unpack(wr_data_i);
                SEL_TLO:  tlo_q  <= wr_data_i;
                SEL_THI:  thi_q  <= wr_data_i;
                default:  ;
            endcase
        end
    end

    logic [ADDR_W-1:0]      scaled;
    logic [ADDR_W-1:0]      way_mask;
    logic [ADDR_W-1:0]      slot_full;
    logic                   slot_ok;
    logic [SLOT_W-1:0]      slot;
    logic [PORT_W-1:0]      lo_field [SLOTS_PER_W];
    logic [PORT_W-1:0]      hi_field [SLOTS_PER_W];

    for (genvar s = 0; s < SLOTS_PER_W; s++) begin : g_field
        assign lo_field[s] = tlo_q[s*PORT_W +: PORT_W];
        assign hi_field[s] = thi_q[s*PORT_W +: PORT_W];
    end

    always_comb begin
        scaled    = abs_addr_i >> gran_shift(ctrl_q.gran);
        way_mask  = (ADDR_W'(1) << ctrl_q.ways) - ADDR_W'(1);
        slot_full = scaled & way_mask;
        slot_ok   = (slot_full >> SLOT_W) == '0;
        slot      = SLOT_W'(slot_full);
        res_o.hit = ctrl_q.commit && slot_ok;
        if (slot[SLOT_W-1])
            res_o.port = hi_field[slot[SLOT_W-2:0]];
        else
            res_o.port = lo_field[slot[SLOT_W-2:0]];
    end

endmodule

// File: rtl/ilv_window_decoder.sv
module ilv_window_decoder
    import ilv_pkg::*;
#(
    parameter int ADDR_W    = 40,
    parameter int DATA_W    = 64,
    parameter int NUM_HB    = 4,
    parameter int TGT_CNT_W = $clog2(NUM_HB + 1),
    parameter int HB_IDX_W  = (NUM_HB > 1) ? $clog2(NUM_HB) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [ADDR_W-1:0]      cfg_win_base,
    input  logic [ADDR_W-1:0]      cfg_win_size,
    input  logic [TGT_CNT_W-1:0]   cfg_win_tgts,
    input  logic                   cfg_gran_set,
    input  logic [GRAN_CODE_W-1:0] cfg_gran_enc,
    output logic                   cfg_err,
    input  logic                   reg_we,
    input  logic [HB_IDX_W-1:0]    reg_hb,
    input  logic [1:0]             reg_sel,
    input  logic [REG_W-1:0]       reg_wdata,
    input  logic                   req_vld,
    input  logic                   req_wr,
    input  logic [ADDR_W-1:0]      req_off,
    input  logic [DATA_W-1:0]      req_wdata,
    output logic                   lk_vld,
    output logic                   lk_hit,
    output logic [HB_IDX_W-1:0]    lk_hb,
    output logic [PORT_W-1:0]      lk_port,
    output logic                   dn_vld,
    output logic                   dn_wr,
    output logic [PORT_W-1:0]      dn_port,
    output logic [ADDR_W-1:0]      dn_addr,
    output logic [DATA_W-1:0]      dn_wdata,
    output logic                   rsp_vld,
    output logic                   rsp_err,
    output logic [DATA_W-1:0]      rsp_rdata
);

    // request stage: one register between strobe and lookup
    logic              stg_vld;
    logic              stg_wr;
    logic [ADDR_W-1:0] stg_abs;
    logic [ADDR_W-1:0] stg_off;
    logic [DATA_W-1:0] stg_wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg_vld   <= 1'b0;
            stg_wr    <= 1'b0;
            stg_abs   <= '0;
            stg_off   <= '0;
            stg_wdata <= '0;
        end else begin
            stg_vld <= req_vld;
            if (req_vld) begin
                stg_wr    <= req_wr;
                stg_abs   <= cfg_win_base + req_off;
                stg_off   <= req_off;
                stg_wdata <= req_wdata;
            end
        end
    end

    // window level: host-bridge choice
    logic                cfg_ok;
    logic                in_range;
    logic [HB_IDX_W-1:0] hb_idx;

    ilv_win_select #(
        .ADDR_W    (ADDR_W),
        .NUM_HB    (NUM_HB),
        .TGT_CNT_W (TGT_CNT_W),
        .HB_IDX_W  (HB_IDX_W)
    ) u_win (
        .win_size_i  (cfg_win_size),
        .win_tgts_i  (cfg_win_tgts),
        .gran_set_i  (cfg_gran_set),
        .gran_code_i (cfg_gran_enc),
        .abs_addr_i  (stg_abs),
        .off_i       (stg_off),
        .cfg_ok_o    (cfg_ok),
        .in_range_o  (in_range),
        .hb_idx_o    (hb_idx)
    );

    // component level: one decoder per host bridge
    dec_res_t dec_res [NUM_HB];

    for (genvar h = 0; h < NUM_HB; h++) begin : g_hb
        logic sel_me;
        assign sel_me = reg_we && (int'(reg_hb) == h);

        ilv_hdm_decoder #(
            .ADDR_W (ADDR_W)
        ) u_dec (
            .clk        (clk),
            .rst        (rst),
            .wr_en_i    (sel_me),
            .wr_sel_i   (reg_sel),
            .wr_data_i  (reg_wdata),
            .abs_addr_i (stg_abs),
            .res_o      (dec_res[h])
        );
    end

    dec_res_t pick;
    logic     hit;

    always_comb begin
        pick = dec_res[hb_idx];
        hit  = cfg_ok && in_range && pick.hit;

        cfg_err   = !cfg_ok;
        lk_vld    = stg_vld;
        lk_hit    = stg_vld && hit;
        lk_hb     = hb_idx;
        lk_port   = pick.port;

        dn_vld    = stg_vld && hit;
        dn_wr     = stg_wr;
        dn_port   = pick.port;
        dn_addr   = stg_abs;
        dn_wdata  = stg_wdata;

        rsp_vld   = stg_vld && !hit;
        rsp_err   = !stg_wr;
        rsp_rdata = '0;
    end

endmodule

// File: rtl/ilv_window_decoder_chk.sv
module ilv_window_decoder_chk
    import ilv_pkg::*;
#(
    parameter int ADDR_W    = 40,
    parameter int DATA_W    = 64,
    parameter int NUM_HB    = 4,
    parameter int TGT_CNT_W = $clog2(NUM_HB + 1),
    parameter int HB_IDX_W  = (NUM_HB > 1) ? $clog2(NUM_HB) : 1
) (
    input logic                 clk,
    input logic                 rst,
    input logic [ADDR_W-1:0]    cfg_win_base,
    input logic                 cfg_err,
    input logic                 req_vld,
    input logic                 req_wr,
    input logic [ADDR_W-1:0]    req_off,
    input logic                 lk_vld,
    input logic                 lk_hit,
    input logic                 dn_vld,
    input logic [ADDR_W-1:0]    dn_addr,
    input logic                 rsp_vld,
    input logic                 rsp_err,
    input logic [DATA_W-1:0]    rsp_rdata
);

    AST_LK_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
        req_vld |=> lk_vld);  // R2

    AST_LK_ONLY_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        !req_vld |=> !lk_vld);  // R2

    AST_DN_RSP_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(dn_vld && rsp_vld));  // R11

    AST_MISS_ERR_DIR: assert property (@(posedge clk) disable iff (rst)
        req_vld |=> (rsp_vld -> (rsp_err == !$past(req_wr))));  // R9

    AST_MISS_ZERO_DATA: assert property (@(posedge clk) disable iff (rst)
        rsp_vld |-> (rsp_rdata == '0));  // R9

    AST_BAD_CFG_MISS: assert property (@(posedge clk) disable iff (rst)
        (lk_vld && cfg_err) |-> !lk_hit);  // R7

    AST_DN_ABS_ADDR: assert property (@(posedge clk) disable iff (rst)
        req_vld |=> (dn_vld -> (dn_addr == $past(req_off) + $past(cfg_win_base))));  // R11

endmodule

bind ilv_window_decoder ilv_window_decoder_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .NUM_HB    (NUM_HB),
    .TGT_CNT_W (TGT_CNT_W),
    .HB_IDX_W  (HB_IDX_W)
) u_chk (.*);

// File: tb/ilv_window_decoder_tb.sv
module ilv_window_decoder_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 40;
    localparam int DW = 64;
    localparam logic [AW-1:0] BASE = 40'h03_0000_0000;
    localparam logic [AW-1:0] SIZE = 40'h00_4000_0000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] cfg_win_base = BASE;
    logic [AW-1:0] cfg_win_size = SIZE;
    logic [2:0]    cfg_win_tgts = 3'd2;
    logic          cfg_gran_set = 1'b0;
    logic [3:0]    cfg_gran_enc = 4'd0;
    logic          cfg_err;
    logic          reg_we = 1'b0;
    logic [1:0]    reg_hb = '0;
    logic [1:0]    reg_sel = '0;
    logic [31:0]   reg_wdata = '0;
    logic          req_vld = 1'b0;
    logic          req_wr = 1'b0;
    logic [AW-1:0] req_off = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          lk_vld, lk_hit, dn_vld, dn_wr, rsp_vld, rsp_err;
    logic [1:0]    lk_hb;
    logic [7:0]    lk_port, dn_port;
    logic [AW-1:0] dn_addr;
    logic [DW-1:0] dn_wdata, rsp_rdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    ilv_window_decoder dut_i (.*);

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wreg(input logic [1:0] hb, input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_hb = hb; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    // strobe one request; on return the lookup outputs are valid
    task automatic access(input logic [AW-1:0] off, input logic wr, input logic [DW-1:0] wd);
        @(negedge clk);
        req_vld = 1'b1; req_wr = wr; req_off = off; req_wdata = wd;
        @(negedge clk);
        req_vld = 1'b0;
    endtask

    task automatic expect_hit(input string req, input logic [1:0] hb, input logic [7:0] port);
        check({req, " hit"}, 64'(dn_vld && lk_hit && !rsp_vld), 64'd1);
        check({req, " hb"}, 64'(lk_hb), 64'(hb));
        check({req, " port"}, 64'(dn_port), 64'(port));
    endtask

    task automatic expect_rd_miss(input string req);
        check({req, " miss"}, 64'({lk_vld, lk_hit, dn_vld, rsp_vld, rsp_err}), 64'b10011);
        check({req, " rdata"}, rsp_rdata, 64'd0);
    endtask

    typedef struct packed {
        logic [AW-1:0] off;
        logic          wr;
        logic          hit;
        logic [1:0]    hb;
        logic [7:0]    port;
    } vec_t;

    // base 0x3_0000_0000, two bridges, window granularity 256 B
    // bridge 0: IG=1 IW=2; bridge 1: IG=0 IW=3
    localparam vec_t VECS [9] = '{
        '{40'h000,        1'b0, 1'b1, 2'd0, 8'h11},
        '{40'h100,        1'b0, 1'b1, 2'd1, 8'hA1},
        '{40'h600,        1'b1, 1'b1, 2'd0, 8'h44},
        '{40'h700,        1'b0, 1'b1, 2'd1, 8'hA7},
        '{40'h400,        1'b0, 1'b1, 2'd0, 8'h33},
        '{40'h500,        1'b1, 1'b1, 2'd1, 8'hA5},
        '{40'h1A00,       1'b0, 1'b1, 2'd0, 8'h22},
        '{40'h3FFF_FF00,  1'b0, 1'b1, 2'd1, 8'hA7},
        '{40'h4000_0000,  1'b0, 1'b0, 2'd0, 8'h00}
    };

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 idle outputs", 64'({lk_vld, dn_vld, rsp_vld}), 64'd0);
        access(40'h000, 1'b0, '0);
        expect_rd_miss("R1 uncommitted after reset");

        check("R7 valid cfg", 64'(cfg_err), 64'd0);

        wreg(2'd0, 2'd0, 32'h0000_0121);
        wreg(2'd0, 2'd1, 32'h4433_2211);
        wreg(2'd0, 2'd2, 32'h8877_6655);
        wreg(2'd1, 2'd0, 32'h0000_0130);
        wreg(2'd1, 2'd1, 32'hA3A2_A1A0);
        wreg(2'd1, 2'd2, 32'hA7A6_A5A4);
        wreg(2'd0, 2'd3, 32'h0000_0000);   // R12 select 3 ignored

        for (int i = 0; i < 9; i++) begin
            access(VECS[i].off, VECS[i].wr, 64'hD00D_0000 + 64'(i));
            if (VECS[i].hit) begin
                expect_hit($sformatf("R6 vec%0d", i), VECS[i].hb, VECS[i].port);
                check($sformatf("R11 vec%0d addr", i), 64'(dn_addr), 64'(BASE + VECS[i].off));
                check($sformatf("R11 vec%0d dir", i), 64'(dn_wr), 64'(VECS[i].wr));
                if (VECS[i].wr)
                    check($sformatf("R11 vec%0d wdata", i), dn_wdata, 64'hD00D_0000 + 64'(i));
            end else begin
                expect_rd_miss($sformatf("R8 vec%0d", i));
            end
        end

        access(40'h4000_0000, 1'b1, 64'h55);
        check("R10 write miss", 64'({dn_vld, rsp_vld, rsp_err}), 64'b010);
        @(negedge clk);
        check("R2 lookup valid one cycle only", 64'(lk_vld), 64'd0);

        wreg(2'd1, 2'd0, 32'h0000_0030);
        access(40'h100, 1'b0, '0);
        expect_rd_miss("R4 commit clear");
        wreg(2'd1, 2'd0, 32'h0000_0140);
        access(40'h900, 1'b0, '0);
        expect_rd_miss("R5 slot beyond list");
        access(40'h300, 1'b0, '0);
        expect_hit("R5 sixteen ways low slot", 2'd1, 8'hA3);
        wreg(2'd1, 2'd0, 32'h0000_0130);

        cfg_gran_set = 1'b1; cfg_gran_enc = 4'd2;
        access(40'h400, 1'b0, '0);
        expect_hit("R3 window gran 1KiB", 2'd1, 8'hA4);
        access(40'h300, 1'b0, '0);
        expect_hit("R3 window gran 1KiB low", 2'd0, 8'h22);
        cfg_gran_set = 1'b0;

        cfg_win_tgts = 3'd3;
        access(40'h200, 1'b0, '0);
        expect_rd_miss("R3 three-way to uncommitted bridge");
        check("R3 three-way index", 64'(lk_hb), 64'd2);
        access(40'h300, 1'b0, '0);
        expect_hit("R3 three-way wrap", 2'd0, 8'h22);
        cfg_win_tgts = 3'd2;

        cfg_win_size = 40'h00_4000_0100;
        #1;
        check("R7 misaligned size", 64'(cfg_err), 64'd1);
        access(40'h000, 1'b0, '0);
        expect_rd_miss("R7 misaligned size blocks");
        cfg_win_size = SIZE;
        cfg_win_tgts = 3'd0;
        #1;
        check("R7 zero targets", 64'(cfg_err), 64'd1);
        cfg_win_tgts = 3'd2;
        access(40'h000, 1'b1, 64'h1234);
        expect_hit("R12 ctrl kept after select 3", 2'd0, 8'h11);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule